// File: doc/BRIEF.md
# Eight-Pin Bidirectional GPIO Port

This block controls a byte-wide port of general-purpose pins from a simple memory-mapped bus. Software writes a direction byte and a level byte and reads back the pin levels. For each pin the block drives three pad controls: a drive enable, a driven value and a weak pull-up enable.

The level byte does two jobs. On a pin set as an output, its bit is the level driven onto the pad. On a pin set as an input, its bit turns the weak pull-up on or off. One pin position, bit 3 by default, is wired as an input with pull-up, whatever the registers hold.

Pad levels enter through a two-flop synchronizer. Software reads them at a read-only address. That read works whatever the pin's direction, so an output pin's actual level can be read back too.

Top module: `gpio_port`

## Requirements
- R1: After reset both the direction and level registers read 0x00, and every pin is a high-impedance input (oe=0, pu=0, out=0), except pin 3, which has pu=1.
- R2: A pin whose direction bit is 1 drives: oe=1 and pu=0, with out=1 when its level bit is 1 and out=0 when its level bit is 0.
- R3: A pin whose direction bit is 0 does not drive (oe=0, out=0). Its level bit enables the pull-up: pu=1 when the level bit is 1, and pu=0 (high impedance) when it is 0.
- R4: Pin 3 always has oe=0, out=0 and pu=1, whatever is written to bit 3 of either register.
- R5: oe and pu are never both 1 on the same pin.
- R6: Address 0 (direction) and address 1 (level) read back the full byte last written to them, bit 3 included.
- R7: Address 2 returns the pin input levels through two flops. A pin change made before a clock edge appears on the read data after the second rising edge, whatever the pin's direction.
- R8: Writes to address 2 or 3 leave both registers and all pad controls unchanged. Address 3 reads 0x00.
- R9: A write strobe with address 0 or 1 updates the register on the rising edge where the strobe is high. The pads and the read data show the new value only after that edge. Reads are combinational on the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register address: 0 direction, 1 level, 2 pin input, 3 unused |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| pin_i | input | 8 | Raw pad input levels |
| pad_oe_o | output | 8 | Per-pin drive enable |
| pad_out_o | output | 8 | Per-pin driven level |
| pad_pu_o | output | 8 | Per-pin weak pull-up enable |

## Verification
The assertions check the following on every cycle:
- pull-up and drive are never both on for a pin;
- the fixed pin stays an input with pull-up;
- a register write lands one edge after the strobe;
- strobes to the read-only addresses change nothing;
- the input path has exactly two cycles of latency.

Only the bench's scenarios can show the four-way decode of direction and level against explicit expected bytes, full-byte readback including bit 3, the reset state, and reading pin levels while pins are configured as outputs.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_DIR = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LVL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PIN = 2'd2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;

  // cycles since reset, saturating, so $past(...,2) is only used once valid
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // R7
  sync_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  pin_sync_i,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  lvl_o,
  output logic [WIDTH-1:0]  rdata_o
);
  logic [WIDTH-1:0] dir_q, lvl_q;
  logic wr_dir, wr_lvl;

  assign wr_dir = wr_en_i && (addr_i == ADDR_DIR);
  assign wr_lvl = wr_en_i && (addr_i == ADDR_LVL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      lvl_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata_i;
      if (wr_lvl) lvl_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_DIR: rdata_o = dir_q;
      ADDR_LVL: rdata_o = lvl_q;
      ADDR_PIN: rdata_o = pin_sync_i;
      default:  rdata_o = '0;
    endcase
  end

  assign dir_o = dir_q;
  assign lvl_o = lvl_q;

  // R9
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_DIR) |=> (dir_q == $past(wdata_i)));
  // R9
  lvl_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_LVL) |=> (lvl_q == $past(wdata_i)));
  // R8
  ro_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[1]) |=> ($stable(dir_q) && $stable(lvl_q)));
endmodule

// File: rtl/gpio_pad_bit.sv
module gpio_pad_bit #(
  parameter bit FORCE_IN_PU = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_i,
  input  logic lvl_i,
  output logic oe_o,
  output logic out_o,
  output logic pu_o
);
  localparam logic FIXED = FORCE_IN_PU;

  // level bit: driven value when output, pull-up select when input
  assign oe_o  = dir_i & ~FIXED;
  assign out_o = dir_i & lvl_i & ~FIXED;
  assign pu_o  = (~dir_i & lvl_i) | FIXED;

  // R5
  oe_pu_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(oe_o && pu_o));

  generate
    if (FORCE_IN_PU) begin : g_fixed_chk
      // R4
      fixed_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!oe_o && !out_o && pu_o));
    end
  endgenerate
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned FIXED_PIN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pad_oe_o,
  output logic [WIDTH-1:0]  pad_out_o,
  output logic [WIDTH-1:0]  pad_pu_o
);
  logic [WIDTH-1:0] pin_sync, dir, lvl;

  gpio_sync #(.WIDTH(WIDTH)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .pin_sync_i(pin_sync),
    .dir_o     (dir),
    .lvl_o     (lvl),
    .rdata_o   (rdata_o)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pad
    gpio_pad_bit #(.FORCE_IN_PU(i == FIXED_PIN)) i_pad (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .dir_i (dir[i]),
      .lvl_i (lvl[i]),
      .oe_o  (pad_oe_o[i]),
      .out_o (pad_out_o[i]),
      .pu_o  (pad_pu_o[i])
    );
  end
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
  localparam time TCLK = 4ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] pin = 8'h00;
  logic [7:0] rdata, oe, out, pu;

  int checks = 0;
  int failures = 0;

  always #(TCLK/2) clk = ~clk;

  gpio_port i_gpio_port (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .wr_en_i  (wr_en),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .pin_i    (pin),
    .pad_oe_o (oe),
    .pad_out_o(out),
    .pad_pu_o (pu)
  );

  // {direction, level, exp_oe, exp_out, exp_pu}; pin 3 forced to input with pull-up
  localparam logic [39:0] VEC [6] = '{
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h08},
    {8'hFF, 8'hFF, 8'hF7, 8'hF7, 8'h08},
    {8'hFF, 8'h00, 8'hF7, 8'h00, 8'h08},
    {8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF},
    {8'hA5, 8'h3C, 8'hA5, 8'h24, 8'h18},
    {8'h0F, 8'hF0, 8'h07, 8'h00, 8'hF8}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    #(TCLK * 100000);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state, held in reset
    chk("R1 oe", oe, 8'h00);
    chk("R1 pu", pu, 8'h08);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, r); chk("R1 dir", r, 8'h00);
    rd(2'd1, r); chk("R1 lvl", r, 8'h00);
    chk("R1 out", out, 8'h00);

    foreach (VEC[i]) begin
      wr(2'd0, VEC[i][39:32]);
      wr(2'd1, VEC[i][31:24]);
      rd(2'd0, r); chk("R6 dir readback", r, VEC[i][39:32]);
      rd(2'd1, r); chk("R6 lvl readback", r, VEC[i][31:24]);
      chk("R2/R4 oe", oe, VEC[i][23:16]);
      chk("R2/R3 out", out, VEC[i][15:8]);
      chk("R3/R4/R5 pu", pu, VEC[i][7:0]);
    end

    // R7: pins read while all configured as outputs
    wr(2'd0, 8'hFF);
    addr = 2'd2;
    pin = 8'h5A;
    #1;
    chk("R7 before edges", rdata, 8'h00);
    @(negedge clk); #1;
    chk("R7 after one edge", rdata, 8'h00);
    @(negedge clk); #1;
    chk("R7 after two edges", rdata, 8'h5A);
    wr(2'd0, 8'h00);
    pin = 8'hC3;
    repeat (2) @(negedge clk);
    rd(2'd2, r); chk("R7 inputs", r, 8'hC3);

    // R8: writes to read-only addresses ignored
    wr(2'd0, 8'h81);
    wr(2'd1, 8'h42);
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    rd(2'd0, r); chk("R8 dir kept", r, 8'h81);
    rd(2'd1, r); chk("R8 lvl kept", r, 8'h42);
    rd(2'd3, r); chk("R8 addr3 reads zero", r, 8'h00);
    chk("R8 oe kept", oe, 8'h81);
    chk("R8 pu kept", pu, 8'h4A);

    // R9: update lands only at the edge with strobe
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd0; wdata = 8'h10;
    #1;
    chk("R9 before edge", oe, 8'h81);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 after edge", oe, 8'h10);

    // R4: bit 3 set in both registers
    wr(2'd0, 8'h08);
    wr(2'd1, 8'h08);
    chk("R4 oe", oe, 8'h00);
    chk("R4 out", out, 8'h00);
    chk("R4 pu", pu, 8'h08);
    rd(2'd0, r); chk("R6 bit3 dir", r, 8'h08);

    // R1: reset again clears registers
    rst_n = 1'b0;
    #1;
    rst_n = 1'b1;
    rd(2'd1, r); chk("R1 reapply lvl", r, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule